// File: doc/BRIEF.md
# Address Region Security Filter

This block judges every memory access that arrives on one of several filter ports against a small table of programmable address regions, and answers allow or deny one cycle later. An access carries an address, a direction, a secure/non-secure flag, a privilege flag, a 4-bit requester identifier and the index of the filter port it arrived on. For each region the table holds a base, an inclusive top, a bitmap of the filters it applies to, a two-bit secure permission and a 32-bit requester permission mask.

Region 0 is a permanent background region. It covers the whole address space on every filter, and only its permission fields can be changed. Where several regions match, the highest-numbered one decides, and a match by two or more of regions 1 and above is flagged as an overlap. Each filter also has a gate. Configuration requests the gate state, the observed state follows two cycles later on `gate_status`, and a filter whose observed gate is closed denies everything. Configuration goes through a single write port that selects a region and a field.

Top module: `region_sec_filter`

## Requirements
- R1: During and after reset, `rsp_valid`, `rsp_allow`, `rsp_overlap` and `gate_status` are 0. Regions 1 and up have no filter enabled, and all permissions are 0.
- R2: A write of field code 6 loads `cfg_wdata[NUM_FILTERS-1:0]` as the requested gate state, and `cfg_region` is ignored for this field. `gate_status` shows the new value on the third clock edge after the edge that takes the write, and not earlier.
- R3: An access on a filter whose bit in `gate_status` is 0 at the sampling edge is denied, whatever the region permissions say.
- R4: Region 0 matches every address on every filter. Writes of field codes 0 to 3 to region 0, and the filter bitmap in a field 4 write to region 0, are ignored. Its secure permission and requester mask remain writable.
- R5: A region matches when base <= address <= top, compared over all ADDR_W bits. On a write the low 12 bits of the base are stored as 0 and the low 12 bits of the top are stored as 1.
- R6: A region other than 0 can match only on filters whose bit is set in its filter bitmap, which is bits [NUM_FILTERS-1:0] of a field 4 write.
- R7: When several regions match, the highest-numbered matching region supplies the permission.
- R8: `rsp_overlap` is 1 when two or more regions numbered 1 or above match the access on its filter. This is independent of the gate state.
- R9: A secure access (`acc_nonsec`=0) is checked only against the region's secure field, which is bits [31:30] of field 4. Bit 30 grants reads and bit 31 grants writes, so 0 is none, 1 is read, 2 is write and 3 is both.
- R10: A non-secure access is checked only against the region's requester mask (field 5). Bit `acc_id` grants a read, and bit 16+`acc_id` grants a write.
- R11: `acc_priv` has no effect on the response.
- R12: Each cycle with `acc_valid` high produces exactly one response with `rsp_valid` high on the next cycle. Otherwise `rsp_valid`, `rsp_allow` and `rsp_overlap` are 0.
- R13: Field codes on `cfg_sel`: 0 is base bits [31:0], 1 is base bits [ADDR_W-1:32], 2 is top bits [31:0], 3 is top bits [ADDR_W-1:32], 4 is the attributes, 5 is the requester mask and 6 is the gate. Writes to a region index of NUM_REGIONS or above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | RIDX_W | Target region of the write |
| cfg_sel | input | 3 | Field code (R13) |
| cfg_wdata | input | 32 | Write data |
| gate_status | output | NUM_FILTERS | Observed gate state per filter |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_nonsec | input | 1 | 1 for a non-secure access |
| acc_priv | input | 1 | Privilege flag (no effect) |
| acc_id | input | 4 | Requester identifier |
| acc_filter | input | FIDX_W | Filter port of the access |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_overlap | output | 1 | Overlap among regions 1 and up |

## Verification
A corrupted region field, such as a base, top or bitmap bit, only shows when an access lands near the affected boundary or on the affected filter. The bench therefore probes addresses at the first and last byte of each region, one byte outside it, and on filters inside and outside the bitmap, and the wrong decision appears on `rsp_allow` one cycle after the probe. A wrong gate pipeline stage shows on `gate_status` within three cycles of a gate write. A wrong priority or overlap count shows on the first access that hits stacked regions.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int CFG_W    = 32;
  localparam int PAGE_W   = 12;
  localparam int REQ_ID_W = 4;

  typedef enum logic [2:0] {
    FLD_BASE_LO = 3'd0,
    FLD_BASE_HI = 3'd1,
    FLD_TOP_LO  = 3'd2,
    FLD_TOP_HI  = 3'd3,
    FLD_ATTR    = 3'd4,
    FLD_IDMASK  = 3'd5,
    FLD_GATE    = 3'd6
  } cfg_field_e;
endpackage

// File: rtl/sf_region.sv
module sf_region
  import sf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NF     = 4,
  parameter bit FIXED  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NF-1:0]     hit_vec,
  output logic [1:0]        perm_sec,
  output logic [CFG_W-1:0]  perm_id
);
  localparam int HI_W = ADDR_W - 32;

  logic [1:0]        sec_q, sec_d;
  logic [CFG_W-1:0]  idm_q, idm_d;
  logic [ADDR_W-1:0] base_w, top_w;
  logic [NF-1:0]     fen_w;
  logic              in_range;

  always_comb begin
    sec_d = sec_q;
    idm_d = idm_q;
    if (wr_en) begin
      if (cfg_field_e'(wr_sel) == FLD_ATTR)   sec_d = wr_data[31:30];
      if (cfg_field_e'(wr_sel) == FLD_IDMASK) idm_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      idm_q <= '0;
    end else if (wr_en) begin
      sec_q <= sec_d;
      idm_q <= idm_d;
    end
  end

  generate
    if (FIXED) begin : g_fixed
      assign base_w = '0;
      assign top_w  = '1;
      assign fen_w  = '1;
    end else begin : g_prog
      logic [ADDR_W-1:PAGE_W] base_q, base_d, top_q, top_d;
      logic [NF-1:0]          fen_q, fen_d;

      always_comb begin
        base_d = base_q;
        top_d  = top_q;
        fen_d  = fen_q;
        if (wr_en) begin
          case (cfg_field_e'(wr_sel))
            FLD_BASE_LO: base_d[31:PAGE_W]     = wr_data[31:PAGE_W];
            FLD_BASE_HI: base_d[ADDR_W-1:32]   = wr_data[HI_W-1:0];
            FLD_TOP_LO:  top_d[31:PAGE_W]      = wr_data[31:PAGE_W];
            FLD_TOP_HI:  top_d[ADDR_W-1:32]    = wr_data[HI_W-1:0];
            FLD_ATTR:    fen_d                 = wr_data[NF-1:0];
            default: ;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q <= '0;
          top_q  <= '0;
          fen_q  <= '0;
        end else if (wr_en) begin
          base_q <= base_d;
          top_q  <= top_d;
          fen_q  <= fen_d;
        end
      end

      assign base_w = {base_q, {PAGE_W{1'b0}}};
      assign top_w  = {top_q,  {PAGE_W{1'b1}}};
      assign fen_w  = fen_q;
    end
  endgenerate

  assign in_range = (acc_addr >= base_w) && (acc_addr <= top_w);
  assign hit_vec  = fen_w & {NF{in_range}};
  assign perm_sec = sec_q;
  assign perm_id  = idm_q;
endmodule

// File: rtl/sf_gate.sv
module sf_gate #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_we,
  input  logic [NF-1:0] req_d,
  output logic [NF-1:0] gate_obs
);
  logic [NF-1:0] req_q, mid_q, obs_q;
  logic [NF-1:0] req_nx, mid_nx, obs_nx;

  always_comb begin
    req_nx = req_we ? req_d : req_q;
    mid_nx = req_q;
    obs_nx = mid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      mid_q <= '0;
      obs_q <= '0;
    end else begin
      req_q <= req_nx;
      mid_q <= mid_nx;
      obs_q <= obs_nx;
    end
  end

  assign gate_obs = obs_q;
endmodule

// File: rtl/sf_decide.sv
module sf_decide
  import sf_pkg::*;
#(
  parameter int NR     = 9,
  parameter int NF     = 4,
  parameter int RIDX_W = 4,
  parameter int FIDX_W = 2
) (
  input  logic [NR-1:0][NF-1:0]    hit,
  input  logic [NR-1:0][1:0]       sec,
  input  logic [NR-1:0][CFG_W-1:0] idm,
  input  logic [NF-1:0]            gate_open,
  input  logic [FIDX_W-1:0]        filt,
  input  logic                     is_write,
  input  logic                     is_nonsec,
  input  logic [REQ_ID_W-1:0]      req_id,
  output logic                     allow,
  output logic                     overlap
);
  logic [RIDX_W-1:0] win;
  logic [RIDX_W:0]   extra;
  logic              ok_sec, ok_id;

  always_comb begin
    win   = '0;
    extra = '0;
    for (int r = 0; r < NR; r++) begin
      if (hit[r][filt]) begin
        win = RIDX_W'(r);
        if (r != 0) extra = extra + (RIDX_W+1)'(1);
      end
    end
    ok_sec  = sec[win][is_write];
    ok_id   = idm[win][{is_write, req_id}];
    allow   = gate_open[filt] & (is_nonsec ? ok_id : ok_sec);
    overlap = (extra > (RIDX_W+1)'(1));
  end
endmodule

// File: rtl/region_sec_filter.sv
module region_sec_filter
  import sf_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  localparam int RIDX_W = $clog2(NUM_REGIONS),
  localparam int FIDX_W = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [RIDX_W-1:0]      cfg_region,
  input  logic [2:0]             cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [NUM_FILTERS-1:0] gate_status,
  input  logic                   acc_valid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  logic                   acc_nonsec,
  input  logic                   acc_priv,
  input  logic [REQ_ID_W-1:0]    acc_id,
  input  logic [FIDX_W-1:0]      acc_filter,
  output logic                   rsp_valid,
  output logic                   rsp_allow,
  output logic                   rsp_overlap
);
  logic rst_meta_q, rst_q;
  logic unused_priv;

  logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] hit;
  logic [NUM_REGIONS-1:0][1:0]             sec;
  logic [NUM_REGIONS-1:0][CFG_W-1:0]       idm;
  logic                                    gate_we;
  logic                                    allow_c, overlap_c;
  logic                                    rv_d, ra_d, ro_d;
  logic                                    rv_q, ra_q, ro_q;

  assign unused_priv = acc_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign gate_we = cfg_we && (cfg_field_e'(cfg_sel) == FLD_GATE);

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
      logic sel_we;
      assign sel_we = cfg_we && (cfg_region == RIDX_W'(r)) &&
                      (cfg_field_e'(cfg_sel) != FLD_GATE);
      sf_region #(
        .ADDR_W (ADDR_W),
        .NF     (NUM_FILTERS),
        .FIXED  (r == 0)
      ) u_region (
        .clk      (clk),
        .rst_n    (rst_q),
        .wr_en    (sel_we),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .acc_addr (acc_addr),
        .hit_vec  (hit[r]),
        .perm_sec (sec[r]),
        .perm_id  (idm[r])
      );
    end
  endgenerate

  sf_gate #(.NF(NUM_FILTERS)) u_gate (
    .clk      (clk),
    .rst_n    (rst_q),
    .req_we   (gate_we),
    .req_d    (cfg_wdata[NUM_FILTERS-1:0]),
    .gate_obs (gate_status)
  );

  sf_decide #(
    .NR     (NUM_REGIONS),
    .NF     (NUM_FILTERS),
    .RIDX_W (RIDX_W),
    .FIDX_W (FIDX_W)
  ) u_decide (
    .hit       (hit),
    .sec       (sec),
    .idm       (idm),
    .gate_open (gate_status),
    .filt      (acc_filter),
    .is_write  (acc_write),
    .is_nonsec (acc_nonsec),
    .req_id    (acc_id),
    .allow     (allow_c),
    .overlap   (overlap_c)
  );

  always_comb begin
    rv_d = acc_valid;
    ra_d = acc_valid & allow_c;
    ro_d = acc_valid & overlap_c;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
      ro_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      ra_q <= ra_d;
      ro_q <= ro_d;
    end
  end

  assign rsp_valid   = rv_q;
  assign rsp_allow   = ra_q;
  assign rsp_overlap = ro_q;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int NF     = 4,
  parameter int FIDX_W = 2
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cfg_we,
  input logic [2:0]        cfg_sel,
  input logic [31:0]       cfg_wdata,
  input logic [NF-1:0]     gate_status,
  input logic              acc_valid,
  input logic [FIDX_W-1:0] acc_filter,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic              rsp_overlap
);
  a_r2_gate_lag: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_we && cfg_sel == 3'd6) |=> ##2 (gate_status == $past(cfg_wdata[NF-1:0], 3)));

  a_r3_closed_denies: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_valid && !gate_status[acc_filter]) |=> !rsp_allow);

  a_r12_one_response: assert property (@(posedge clk) disable iff (!rst_q)
    acc_valid |=> rsp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    !acc_valid |=> !rsp_valid);

  a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_q)
    !rsp_valid |-> (!rsp_allow && !rsp_overlap));
endmodule

bind region_sec_filter sf_checker #(.NF(NUM_FILTERS), .FIDX_W(FIDX_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .gate_status (gate_status),
  .acc_valid   (acc_valid),
  .acc_filter  (acc_filter),
  .rsp_valid   (rsp_valid),
  .rsp_allow   (rsp_allow),
  .rsp_overlap (rsp_overlap)
);

// File: tb/sim_region_sec_filter.sv
`timescale 1ns/1ps
module sim_region_sec_filter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int NR = 9;
  localparam int NF = 4;
  localparam logic [63:0] AMASK = (64'h1 << AW) - 64'h1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_region = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  gate_status;
  logic        acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic        acc_write = 1'b0, acc_nonsec = 1'b0, acc_priv = 1'b0;
  logic [3:0]  acc_id = '0;
  logic [1:0]  acc_filter = '0;
  logic        rsp_valid, rsp_allow, rsp_overlap;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_sec_filter #(.ADDR_W(AW), .NUM_REGIONS(NR), .NUM_FILTERS(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .gate_status(gate_status),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_nonsec(acc_nonsec), .acc_priv(acc_priv), .acc_id(acc_id),
    .acc_filter(acc_filter), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_overlap(rsp_overlap));

  // Behavioural reference model, stepped on every rising edge
  logic [63:0] m_base [NR];
  logic [63:0] m_top  [NR];
  logic [3:0]  m_fen  [NR];
  logic [1:0]  m_sec  [NR];
  logic [31:0] m_idm  [NR];
  logic [3:0]  m_gq, m_g1, m_gobs;
  logic        m_rv, m_ra, m_ro, m_rs1, m_rs2;
  int          m_win, m_cnt;
  logic        m_ok;

  initial begin
    m_rs1 = 1'b0; m_rs2 = 1'b0;
    m_rv = 1'b0; m_ra = 1'b0; m_ro = 1'b0;
    m_gq = '0; m_g1 = '0; m_gobs = '0;
  end

  always @(posedge clk) begin
    if (!m_rs2) begin
      for (int r = 0; r < NR; r++) begin
        m_base[r] = 64'h0;
        m_top[r]  = (r == 0) ? AMASK : 64'hFFF;
        m_fen[r]  = (r == 0) ? 4'hF : 4'h0;
        m_sec[r]  = 2'b00;
        m_idm[r]  = 32'h0;
      end
      m_gq = '0; m_g1 = '0; m_gobs = '0;
      m_rv = 1'b0; m_ra = 1'b0; m_ro = 1'b0;
    end else begin
      m_rv = acc_valid; m_ra = 1'b0; m_ro = 1'b0;
      if (acc_valid) begin
        m_win = 0; m_cnt = 0;
        for (int r = 1; r < NR; r++)
          if (m_fen[r][acc_filter] && {24'h0, acc_addr} >= m_base[r] &&
              {24'h0, acc_addr} <= m_top[r]) begin
            m_win = r; m_cnt++;
          end
        if (acc_nonsec) m_ok = m_idm[m_win][acc_write ? 16 + int'(acc_id) : int'(acc_id)];
        else            m_ok = m_sec[m_win][acc_write ? 1 : 0];
        m_ra = m_gobs[acc_filter] && m_ok;
        m_ro = (m_cnt >= 2);
      end
      m_gobs = m_g1;
      m_g1   = m_gq;
      if (cfg_we) begin
        if (cfg_sel == 3'd6) m_gq = cfg_wdata[3:0];
        else if (int'(cfg_region) < NR) begin
          automatic int r = int'(cfg_region);
          case (cfg_sel)
            3'd0: if (r != 0) begin m_base[r][31:0] = cfg_wdata; m_base[r][11:0] = 12'h0; m_base[r] &= AMASK; end
            3'd1: if (r != 0) begin m_base[r][63:32] = cfg_wdata; m_base[r] &= AMASK; end
            3'd2: if (r != 0) begin m_top[r][31:0] = cfg_wdata; m_top[r][11:0] = 12'hFFF; m_top[r] &= AMASK; end
            3'd3: if (r != 0) begin m_top[r][63:32] = cfg_wdata; m_top[r] &= AMASK; end
            3'd4: begin m_sec[r] = cfg_wdata[31:30]; if (r != 0) m_fen[r] = cfg_wdata[3:0]; end
            3'd5: m_idm[r] = cfg_wdata;
            default: ;
          endcase
        end
      end
    end
    m_rs2 = m_rs1;
    m_rs1 = rst_n;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R12 model rsp_valid", {63'h0, rsp_valid}, {63'h0, m_rv});
      check("R7 R9 R10 model rsp_allow", {63'h0, rsp_allow}, {63'h0, m_ra});
      check("R8 model rsp_overlap", {63'h0, rsp_overlap}, {63'h0, m_ro});
      check("R2 model gate_status", {60'h0, gate_status}, {60'h0, m_gobs});
    end
  end

  task automatic cfg(input int region, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_region = 4'(region); cfg_sel = 3'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string tag, input logic [AW-1:0] addr, input bit wr,
                        input bit ns, input bit pv, input int id, input int filt,
                        input bit exp_allow, input bit exp_ovl);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = addr; acc_write = wr; acc_nonsec = ns;
    acc_priv = pv; acc_id = 4'(id); acc_filter = 2'(filt);
    @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " valid"}, {63'h0, rsp_valid}, 64'h1);
    check({tag, " allow"}, {63'h0, rsp_allow}, {63'h0, exp_allow});
    check({tag, " overlap"}, {63'h0, rsp_overlap}, {63'h0, exp_ovl});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {63'h0, rsp_valid}, 64'h0);
    check("R1 gate in reset", {60'h0, gate_status}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 gate after reset", {60'h0, gate_status}, 64'h0);
    check("R1 rsp after reset", {62'h0, rsp_allow, rsp_valid}, 64'h0);

    // Background region fully open, gate still closed
    cfg(0, 4, 32'hC000_0000);
    cfg(0, 5, 32'hFFFF_FFFF);
    access("R3 closed gate", 40'h100, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);

    // Gate opening lag
    cfg(0, 6, 32'h0000_000F);
    check("R2 gate lag edge1", {60'h0, gate_status}, 64'h0);
    @(negedge clk);
    check("R2 gate lag edge2", {60'h0, gate_status}, 64'h0);
    @(negedge clk);
    check("R2 gate open edge3", {60'h0, gate_status}, 64'hF);

    // Region 0: address and bitmap writes ignored, permission writable
    cfg(0, 0, 32'h0000_5000);
    cfg(0, 4, 32'h4000_0000);
    access("R4 region0 read ok", 40'h0, 1'b0, 1'b0, 1'b0, 0, 2, 1'b1, 1'b0);
    access("R9 region0 write denied", 40'h0, 1'b1, 1'b0, 1'b0, 0, 2, 1'b0, 1'b0);
    access("R4 region0 high addr", 40'h80_0001_0000, 1'b0, 1'b0, 1'b0, 0, 3, 1'b1, 1'b0);

    // Region 1: base 0x10000, top 0x1FFFF, filter 0 only, no secure rights
    cfg(1, 0, 32'h0001_0ABC);
    cfg(1, 2, 32'h0001_F000);
    cfg(1, 4, 32'h0000_0001);
    cfg(1, 5, 32'h0020_0008);
    access("R5 R13 base inclusive", 40'h1_0000, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    access("R5 R13 top inclusive", 40'h1_FFFF, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    access("R5 above top", 40'h2_0000, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);
    access("R5 below base", 40'h0_FFFF, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);
    access("R5 high bits differ", 40'h01_0001_0000, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);
    access("R6 other filter", 40'h1_0000, 1'b0, 1'b0, 1'b0, 0, 1, 1'b1, 1'b0);
    access("R10 ns read id3", 40'h1_0800, 1'b0, 1'b1, 1'b0, 3, 0, 1'b1, 1'b0);
    access("R10 ns read id4", 40'h1_0800, 1'b0, 1'b1, 1'b0, 4, 0, 1'b0, 1'b0);
    access("R10 ns write id5", 40'h1_0800, 1'b1, 1'b1, 1'b0, 5, 0, 1'b1, 1'b0);
    access("R10 ns write id3", 40'h1_0800, 1'b1, 1'b1, 1'b0, 3, 0, 1'b0, 1'b0);
    access("R10 ns read id5", 40'h1_0800, 1'b0, 1'b1, 1'b0, 5, 0, 1'b0, 1'b0);
    access("R11 priv ns write", 40'h1_0800, 1'b1, 1'b1, 1'b1, 5, 0, 1'b1, 1'b0);
    access("R11 priv secure read", 40'h1_0000, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
    @(negedge clk);
    check("R12 idle after access", {63'h0, rsp_valid}, 64'h0);

    // Region 2 stacked inside region 1, filters 0 and 1, full secure rights
    cfg(2, 0, 32'h0001_8000);
    cfg(2, 2, 32'h0001_8000);
    cfg(2, 4, 32'hC000_0003);
    access("R7 R8 highest wins", 40'h1_8800, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b1);
    access("R8 single on f1", 40'h1_8800, 1'b0, 1'b0, 1'b0, 0, 1, 1'b1, 1'b0);
    access("R7 outside stack", 40'h1_7000, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);

    // Region 3 above 4 GiB, write only, filter 2
    cfg(3, 1, 32'h0000_0001);
    cfg(3, 3, 32'h0000_0001);
    cfg(3, 2, 32'h0000_0000);
    cfg(3, 4, 32'h8000_0004);
    access("R9 write-only write", 40'h01_0000_0800, 1'b1, 1'b0, 1'b0, 0, 2, 1'b1, 1'b0);
    access("R9 write-only read", 40'h01_0000_0800, 1'b0, 1'b0, 1'b0, 0, 2, 1'b0, 1'b0);

    // Out-of-range region index ignored
    cfg(12, 4, 32'h0000_0000);
    access("R13 bad region ignored", 40'h01_0000_0800, 1'b1, 1'b0, 1'b0, 0, 2, 1'b1, 1'b0);

    // Close filter 2 only
    cfg(5, 6, 32'h0000_000B);
    repeat (2) @(negedge clk);
    check("R2 gate partial close", {60'h0, gate_status}, 64'hB);
    access("R3 closed filter2", 40'h01_0000_0800, 1'b1, 1'b0, 1'b0, 0, 2, 1'b0, 1'b0);
    access("R3 open filter0", 40'h2_0000, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule